// File: doc/BRIEF.md
# Flagless Variable Shift Execution Unit

This unit executes three variable-count integer shifts for a processor datapath: logical left, logical right and arithmetic right. Each accepted operation supplies an already decoded two-bit prefix code, a 64-bit data source, a 64-bit count source, a width bit and three mode and encoding bits. One cycle later the unit returns either a result with a valid strobe or an undefined-opcode fault strobe.

The operand size and the count mask are chosen together. The width bit selects 64-bit operation only while the core is in long mode. Outside long mode the width bit is ignored and the unit behaves as a 32-bit shifter. The unit has no flag outputs and no flag inputs, so no status flag is ever read or changed. Operand fetch, register writeback and full instruction decode are left to the surrounding pipeline.

Top module: `flagless_shift_unit`

## Requirements
- R1: The prefix code selects the operation. 2'b01 is logical left, 2'b10 is arithmetic right and 2'b11 is logical right. Code 2'b00 is not a valid shift and raises a fault.
- R2: The operand size is 64 bits only when the width bit and long mode are both 1. In every other case it is 32 bits, so the width bit has no effect while long mode is 0.
- R3: The effective count is the count source ANDed with 0x3F for 64-bit operation and with 0x1F for 32-bit operation. All higher count bits are discarded.
- R4: An arithmetic right shift copies the operand's top bit (bit 63, or bit 31 in 32-bit operation) into every vacated position.
- R5: A logical right shift fills the vacated high positions with zero. A logical left shift fills the vacated low positions with zero.
- R6: An effective count of zero returns the data source unchanged, truncated to the operand size.
- R7: In 32-bit operation the result occupies bits 31:0 and bits 63:32 of the output are zero.
- R8: A vector-length bit of 1 raises a fault. No valid result is produced and the result bus reads zero.
- R9: The legacy-mode bit set to 1, which stands for real or virtual-8086 execution, raises a fault.
- R10: Each strobed input produces, one cycle later, exactly one of result-valid or fault. A cycle with no input strobe produces neither one.
- R11: After reset, result-valid and fault are 0 and the result bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| pfx_code | input | 2 | Operation select code |
| src_data | input | 64 | Value to shift |
| src_count | input | 64 | Shift count source |
| wide_bit | input | 1 | Requests 64-bit operand size |
| long_mode | input | 1 | Core is in 64-bit mode |
| vlen_bit | input | 1 | Vector-length encoding bit |
| legacy_mode | input | 1 | Real or virtual-8086 execution |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Shift result |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
On every cycle, the assertions check the strobe protocol: exactly one of valid or fault follows each input strobe, neither follows an idle cycle, and the two are never high together. They also check that a fault comes with a zero result bus, that every 32-bit operation has zero upper result bits, and that a masked count of zero in 64-bit mode passes the data through. Only the bench's scenarios can show that the shift values themselves are correct. These cover sign fill, masking at the count boundaries, the width bit being ignored outside long mode, and the mapping of each prefix code.

// File: rtl/flagless_shift_unit.sv
module flagless_shift_unit #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    pfx_code,
  input  logic [DW-1:0] src_data,
  input  logic [DW-1:0] src_count,
  input  logic          wide_bit,
  input  logic          long_mode,
  input  logic          vlen_bit,
  input  logic          legacy_mode,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_fault
);
  localparam int CW = $clog2(DW);
  localparam logic [1:0] OP_SHL = 2'b01;
  localparam logic [1:0] OP_SAR = 2'b10;
  localparam logic [1:0] OP_SHR = 2'b11;

  logic          is_wide;
  logic          bad_enc;
  logic [CW-1:0] cnt;
  logic [DW-1:0] opnd;
  logic [DW-1:0] shifted;
  logic [DW-1:0] res_d;

  assign is_wide = wide_bit & long_mode;
  assign bad_enc = vlen_bit | legacy_mode | (pfx_code == 2'b00);
  assign cnt     = is_wide ? src_count[CW-1:0] : {1'b0, src_count[CW-2:0]};
  assign opnd    = is_wide ? src_data
                 : {{(DW-HW){(pfx_code == OP_SAR) & src_data[HW-1]}}, src_data[HW-1:0]};

  always_comb begin
    unique case (pfx_code)
      OP_SHL:  shifted = opnd << cnt;
      OP_SAR:  shifted = DW'($signed(opnd) >>> cnt);
      OP_SHR:  shifted = opnd >> cnt;
      default: shifted = '0;
    endcase
  end

  assign res_d = is_wide ? shifted : {{(DW-HW){1'b0}}, shifted[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fault  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid  <= in_valid & ~bad_enc;
      out_fault  <= in_valid & bad_enc;
      out_result <= (in_valid & ~bad_enc) ? res_d : '0;
    end
  end

  // R10
  one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid ^ out_fault));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_fault));
  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_result == '0));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(wide_bit && long_mode)) |=> (out_result[DW-1:HW] == '0));
  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !vlen_bit && !legacy_mode && pfx_code != 2'b00 &&
     wide_bit && long_mode && src_count[CW-1:0] == '0)
    |=> (out_result == $past(src_data)));
endmodule

// File: tb/test_flagless_shift_unit.sv
`timescale 1ns/1ps
module test_flagless_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  pfx_code = 2'b00;
  logic [63:0] src_data = '0;
  logic [63:0] src_count = '0;
  logic        wide_bit = 1'b0;
  logic        long_mode = 1'b0;
  logic        vlen_bit = 1'b0;
  logic        legacy_mode = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_fault;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flagless_shift_unit i_flagless_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_code(pfx_code),
    .src_data(src_data), .src_count(src_count), .wide_bit(wide_bit),
    .long_mode(long_mode), .vlen_bit(vlen_bit), .legacy_mode(legacy_mode),
    .out_valid(out_valid), .out_result(out_result), .out_fault(out_fault));

  // {pfx, wide, long, data, count, expected}
  localparam int NV = 12;
  localparam logic [195:0] VEC [NV] = '{
    {2'b01, 1'b1, 1'b1, 64'h1, 64'd63, 64'h8000_0000_0000_0000},
    {2'b01, 1'b1, 1'b1, 64'h1, 64'd64, 64'h1},
    {2'b10, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000},
    {2'b11, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd4, 64'h0800_0000_0000_0000},
    {2'b10, 1'b0, 1'b1, 64'h1234_5678_8000_0000, 64'd4, 64'h0000_0000_F800_0000},
    {2'b10, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'd33, 64'h0000_0000_C000_0000},
    {2'b01, 1'b0, 1'b1, 64'h0000_0000_8000_0001, 64'd1, 64'h2},
    {2'b11, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, 64'h1},
    {2'b10, 1'b1, 1'b1, 64'h7000_0000_0000_0000, 64'h3F, 64'h0},
    {2'b10, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3F, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b11, 1'b0, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 64'h0000_0000_CCCC_DDDD},
    {2'b01, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'd8, 64'h2345_6789_ABCD_EF00}
  };
  localparam string VREQ [NV] = '{"R1 R3", "R3 R6", "R4", "R5", "R4 R7", "R2 R3",
                                  "R5 R7", "R5", "R4", "R4", "R6", "R1 R5"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic w, input logic l,
                       input logic [63:0] d, input logic [63:0] c,
                       input logic vl, input logic lg);
    @(negedge clk);
    in_valid = 1'b1; pfx_code = p; wide_bit = w; long_mode = l;
    src_data = d; src_count = c; vlen_bit = vl; legacy_mode = lg;
    @(posedge clk);
    #1;
    in_valid = 1'b0; vlen_bit = 1'b0; legacy_mode = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 valid", {63'b0, out_valid}, 64'h0);
    chk("R11 fault", {63'b0, out_fault}, 64'h0);
    chk("R11 result", out_result, 64'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][195:194], VEC[i][193], VEC[i][192], VEC[i][191:128],
            VEC[i][127:64], 1'b0, 1'b0);
      chk({VREQ[i], " valid"}, {63'b0, out_valid}, 64'h1);
      chk({VREQ[i], " result"}, out_result, VEC[i][63:0]);
    end

    // R8 vector-length fault
    drive(2'b01, 1'b1, 1'b1, 64'h5, 64'd1, 1'b1, 1'b0);
    chk("R8 fault", {63'b0, out_fault}, 64'h1);
    chk("R8 valid", {63'b0, out_valid}, 64'h0);
    chk("R8 result", out_result, 64'h0);
    // R9 legacy-mode fault
    drive(2'b11, 1'b0, 1'b0, 64'h5, 64'd1, 1'b0, 1'b1);
    chk("R9 fault", {63'b0, out_fault}, 64'h1);
    chk("R9 valid", {63'b0, out_valid}, 64'h0);
    // R1 code 00 faults
    drive(2'b00, 1'b1, 1'b1, 64'h5, 64'd1, 1'b0, 1'b0);
    chk("R1 fault", {63'b0, out_fault}, 64'h1);
    // R10 idle cycle gives neither strobe
    @(posedge clk); #1;
    chk("R10 idle valid", {63'b0, out_valid}, 64'h0);
    chk("R10 idle fault", {63'b0, out_fault}, 64'h0);
    // R10 back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; pfx_code = 2'b11; wide_bit = 1'b1; long_mode = 1'b1;
    src_data = 64'hF0; src_count = 64'd4;
    @(posedge clk); #1;
    chk("R10 first", out_result, 64'hF);
    @(negedge clk);
    src_count = 64'd68;
    @(posedge clk); #1;
    chk("R10 second", out_result, 64'hF);
    chk("R10 second valid", {63'b0, out_valid}, 64'h1);
    @(negedge clk) in_valid = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule